// File: doc/BRIEF.md
# Interrupt Controller Setup Sequencer

This block sits behind the two byte-wide register ports of one programmable interrupt controller and turns the writes that software makes to them into configuration state. Port select 0 is the command port and port select 1 is the data port. A command byte with bit 4 set always starts a fresh setup. After that, the data port accepts the vector-base word, then the optional cascade word and the optional mode word. Which of these follow depends on flags held in the first word. Once setup is complete the block is ready. Data-port writes then load the interrupt mask, and command-port writes are classified as one of two operation commands and announced by a one-cycle strobe to the logic that acts on them.

All stored words are exported, together with the decoded mode flags, for use by the request, priority and end-of-interrupt logic around the block. Writes that make no sense in the current state produce a one-cycle error pulse and leave every register and the state as they were. Every output is registered and changes on the clock edge that samples the write.

Top module: `pic_init_seq`

## Requirements
- R1: After a synchronous reset the state reads 1 (awaiting the first setup word), ready is low, the four setup words, the mask and the first operation register are 0x00, and the second operation register is 0x02.
- R2: A command-port write with bit 4 set stores the byte as setup word 1 and moves to state 2 (awaiting the vector base) from any state, including ready.
- R3: A data-port write in state 2 stores setup word 2. The next state is then 3 (awaiting cascade) if word-1 bit 1 (single mode) is 0; otherwise it is 4 (awaiting mode word) if word-1 bit 0 (mode word needed) is 1; otherwise it is 5 (ready).
- R4: A data-port write in state 3 stores setup word 3 and moves to state 4 if word-1 bit 0 is 1, otherwise to state 5. A data-port write in state 4 stores setup word 4 and always moves to state 5.
- R5: In state 5, a data-port write loads the interrupt mask and the state stays 5. The mask changes on no other write.
- R6: In state 5, a command-port byte with bits 4:3 = 00 is stored in the first operation register, and the first operation strobe is high for exactly the following cycle.
- R7: In state 5, a command-port byte with bits 4:3 = 01 is stored in the second operation register, and the second operation strobe is high for exactly the following cycle.
- R8: A command-port byte with bit 4 clear outside state 5 raises the command-error pulse for one cycle and changes no register and not the state.
- R9: A data-port write in state 1 raises the data-error pulse for one cycle and changes no register and not the state.
- R10: The decoded flags follow the stored words: single mode = word-1 bit 1, mode word needed = word-1 bit 0, level triggering = word-1 bit 3, automatic end of interrupt = word-4 bit 1, special nesting = word-4 bit 4.
- R11: Ready is high exactly when the state is 5. With write enable low, nothing changes and no pulse is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| wr_sel | input | 1 | 0 = command port, 1 = data port |
| wr_byte | input | 8 | Written byte |
| cfg_state | output | 3 | Setup state: 1 word1, 2 vector base, 3 cascade, 4 mode word, 5 ready |
| ready | output | 1 | Setup complete |
| icw1_q | output | 8 | Stored setup word 1 |
| icw2_q | output | 8 | Stored vector base |
| icw3_q | output | 8 | Stored cascade word |
| icw4_q | output | 8 | Stored mode word |
| imr_q | output | 8 | Interrupt mask |
| ocw2_q | output | 8 | Last first-kind operation command |
| ocw3_q | output | 8 | Last second-kind operation command |
| ocw2_stb | output | 1 | One-cycle first-kind command strobe |
| ocw3_stb | output | 1 | One-cycle second-kind command strobe |
| cmd_err | output | 1 | One-cycle invalid command pulse |
| data_err | output | 1 | One-cycle unexpected data pulse |
| single_mode | output | 1 | Decoded single-controller flag |
| need_icw4 | output | 1 | Decoded mode-word-needed flag |
| level_mode | output | 1 | Decoded level triggering flag |
| auto_eoi | output | 1 | Decoded automatic end-of-interrupt flag |
| special_nested | output | 1 | Decoded special nesting flag |

## Verification
The hardest situations to reach are the less common branches of the state walk. One is the cascade word followed by a mode word. Others are the single-mode path that skips straight to ready, and a fresh setup word arriving while a sequence is half done. The bench reaches each of them with directed setup sequences that vary the two word-1 flags, and follows them with a long run of random port writes. A behavioural model tracks every output and is compared on each cycle, so errors and strobes are also checked in cycles where no write was expected to cause them.

// File: rtl/pic_seq_pkg.sv
package pic_seq_pkg;

    localparam int BYTE_W = 8;

    // Bit positions the state walk and the decoded flags depend on
    localparam int W1_NEED4  = 0;
    localparam int W1_SINGLE = 1;
    localparam int W1_LEVEL  = 3;
    localparam int W4_AEOI   = 1;
    localparam int W4_SFNM   = 4;
    localparam int CMD_SETUP = 4;
    localparam int CMD_KIND  = 3;

    localparam logic [BYTE_W-1:0] OCW3_RST = 8'h02;

    typedef enum logic [2:0] {
        ST_RESET = 3'd0,
        ST_W1    = 3'd1,
        ST_W2    = 3'd2,
        ST_W3    = 3'd3,
        ST_W4    = 3'd4,
        ST_READY = 3'd5
    } seq_state_e;

    typedef enum logic [2:0] {
        WK_NONE,
        WK_SETUP,
        WK_OCW2,
        WK_OCW3,
        WK_DATA,
        WK_BAD_CMD,
        WK_BAD_DATA
    } wr_kind_e;

    typedef struct packed {
        logic [BYTE_W-1:0] w1;
        logic [BYTE_W-1:0] w2;
        logic [BYTE_W-1:0] w3;
        logic [BYTE_W-1:0] w4;
        logic [BYTE_W-1:0] mask;
        logic [BYTE_W-1:0] op2;
        logic [BYTE_W-1:0] op3;
    } cfg_regs_t;

    function automatic wr_kind_e classify(input logic we, input logic sel,
                                          input logic b_setup, input logic b_kind,
                                          input seq_state_e st);
        wr_kind_e k;
        if (!we)
            k = WK_NONE;
        else if (!sel) begin
            if (b_setup)
                k = WK_SETUP;
            else if (st == ST_READY)
                k = b_kind ? WK_OCW3 : WK_OCW2;
            else
                k = WK_BAD_CMD;
        end else begin
            if (st == ST_W2 || st == ST_W3 || st == ST_W4 || st == ST_READY)
                k = WK_DATA;
            else
                k = WK_BAD_DATA;
        end
        return k;
    endfunction

    function automatic seq_state_e after_data(input seq_state_e st,
                                              input logic need4, input logic single);
        seq_state_e n;
        case (st)
            ST_W2:   n = !single ? ST_W3 : (need4 ? ST_W4 : ST_READY);
            ST_W3:   n = need4 ? ST_W4 : ST_READY;
            ST_W4:   n = ST_READY;
            default: n = st;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/pic_cmd_decode.sv
module pic_cmd_decode
    import pic_seq_pkg::*;
(
    input  logic       wr_en,
    input  logic       wr_sel,
    input  logic [1:0] cmd_bits,   // {bit4, bit3} of the written byte
    input  seq_state_e state,
    output wr_kind_e   kind
);
    always_comb kind = classify(wr_en, wr_sel, cmd_bits[1], cmd_bits[0], state);
endmodule

// File: rtl/pic_seq_fsm.sv
module pic_seq_fsm
    import pic_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  wr_kind_e   kind,
    input  logic       need4,
    input  logic       single,
    output seq_state_e state_q
);
    seq_state_e state_d;

    always_comb begin
        state_d = state_q;
        case (kind)
            WK_SETUP: state_d = ST_W2;
            WK_DATA:  state_d = after_data(state_q, need4, single);
            default:  state_d = state_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_W1;
        else     state_q <= state_d;
    end

    a_r2_setup_restarts: assert property (@(posedge clk) disable iff (rst)
        (kind == WK_SETUP) |=> (state_q == ST_W2));

    a_r3_single_skips_cascade: assert property (@(posedge clk) disable iff (rst)
        (kind == WK_DATA && state_q == ST_W2 && single) |=> (state_q != ST_W3));

    a_r4_mode_word_ends: assert property (@(posedge clk) disable iff (rst)
        (kind == WK_DATA && state_q == ST_W4) |=> (state_q == ST_READY));

    a_r8_bad_cmd_holds: assert property (@(posedge clk) disable iff (rst)
        (kind == WK_BAD_CMD) |=> $stable(state_q));
endmodule

// File: rtl/pic_reg_bank.sv
module pic_reg_bank
    import pic_seq_pkg::*;
#(
    parameter int DATA_W = BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  wr_kind_e          kind,
    input  seq_state_e        state,
    input  logic [DATA_W-1:0] wr_byte,
    output cfg_regs_t         regs_q,
    output logic              ocw2_stb,
    output logic              ocw3_stb,
    output logic              cmd_err,
    output logic              data_err
);
    cfg_regs_t regs_d;

    always_comb begin
        regs_d = regs_q;
        case (kind)
            WK_SETUP: regs_d.w1 = wr_byte;
            WK_OCW2:  regs_d.op2 = wr_byte;
            WK_OCW3:  regs_d.op3 = wr_byte;
            WK_DATA: begin
                case (state)
                    ST_W2:    regs_d.w2   = wr_byte;
                    ST_W3:    regs_d.w3   = wr_byte;
                    ST_W4:    regs_d.w4   = wr_byte;
                    ST_READY: regs_d.mask = wr_byte;
                    default:  regs_d      = regs_q;
                endcase
            end
            default: regs_d = regs_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q     <= '0;
            regs_q.op3 <= OCW3_RST;
            ocw2_stb   <= 1'b0;
            ocw3_stb   <= 1'b0;
            cmd_err    <= 1'b0;
            data_err   <= 1'b0;
        end else begin
            regs_q   <= regs_d;
            ocw2_stb <= (kind == WK_OCW2);
            ocw3_stb <= (kind == WK_OCW3);
            cmd_err  <= (kind == WK_BAD_CMD);
            data_err <= (kind == WK_BAD_DATA);
        end
    end

    a_r5_mask_only_in_ready: assert property (@(posedge clk) disable iff (rst)
        !$stable(regs_q.mask) |-> $past(kind == WK_DATA && state == ST_READY));

    a_r9_bad_data_holds: assert property (@(posedge clk) disable iff (rst)
        data_err |-> $stable(regs_q));

    a_r8_bad_cmd_regs_hold: assert property (@(posedge clk) disable iff (rst)
        cmd_err |-> $stable(regs_q));

    a_r6_op2_pulse: assert property (@(posedge clk) disable iff (rst)
        (kind == WK_OCW2) |=> (ocw2_stb && regs_q.op2 == $past(wr_byte)));
endmodule

// File: rtl/pic_init_seq.sv
module pic_init_seq
    import pic_seq_pkg::*;
#(
    parameter int DATA_W = BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_byte,
    output logic [2:0]        cfg_state,
    output logic              ready,
    output logic [DATA_W-1:0] icw1_q,
    output logic [DATA_W-1:0] icw2_q,
    output logic [DATA_W-1:0] icw3_q,
    output logic [DATA_W-1:0] icw4_q,
    output logic [DATA_W-1:0] imr_q,
    output logic [DATA_W-1:0] ocw2_q,
    output logic [DATA_W-1:0] ocw3_q,
    output logic              ocw2_stb,
    output logic              ocw3_stb,
    output logic              cmd_err,
    output logic              data_err,
    output logic              single_mode,
    output logic              need_icw4,
    output logic              level_mode,
    output logic              auto_eoi,
    output logic              special_nested
);
    wr_kind_e   kind;
    seq_state_e state;
    cfg_regs_t  regs;

    pic_cmd_decode u_dec (
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .cmd_bits ({wr_byte[CMD_SETUP], wr_byte[CMD_KIND]}),
        .state    (state),
        .kind     (kind)
    );

    pic_seq_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .kind    (kind),
        .need4   (regs.w1[W1_NEED4]),
        .single  (regs.w1[W1_SINGLE]),
        .state_q (state)
    );

    pic_reg_bank #(.DATA_W(DATA_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .kind     (kind),
        .state    (state),
        .wr_byte  (wr_byte),
        .regs_q   (regs),
        .ocw2_stb (ocw2_stb),
        .ocw3_stb (ocw3_stb),
        .cmd_err  (cmd_err),
        .data_err (data_err)
    );

    assign cfg_state      = state;
    assign ready          = (state == ST_READY);
    assign icw1_q         = regs.w1;
    assign icw2_q         = regs.w2;
    assign icw3_q         = regs.w3;
    assign icw4_q         = regs.w4;
    assign imr_q          = regs.mask;
    assign ocw2_q         = regs.op2;
    assign ocw3_q         = regs.op3;
    assign single_mode    = regs.w1[W1_SINGLE];
    assign need_icw4      = regs.w1[W1_NEED4];
    assign level_mode     = regs.w1[W1_LEVEL];
    assign auto_eoi       = regs.w4[W4_AEOI];
    assign special_nested = regs.w4[W4_SFNM];

    a_r11_pulses_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ocw2_stb, ocw3_stb, cmd_err, data_err}));

    a_r7_op3_needs_ready: assert property (@(posedge clk) disable iff (rst)
        ocw3_stb |-> ready);

    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> !(ocw2_stb || ocw3_stb || cmd_err || data_err));
endmodule

// File: tb/pic_init_seq_test.sv
`timescale 1ns/1ps
module pic_init_seq_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_byte = 8'h00;

    logic [2:0] cfg_state;
    logic       ready, ocw2_stb, ocw3_stb, cmd_err, data_err;
    logic [7:0] icw1_q, icw2_q, icw3_q, icw4_q, imr_q, ocw2_q, ocw3_q;
    logic       single_mode, need_icw4, level_mode, auto_eoi, special_nested;

    int checks = 0;
    int fails  = 0;
    bit active = 1'b0;

    // behavioural reference state
    int m_st = 1;
    int m_w1 = 0, m_w2 = 0, m_w3 = 0, m_w4 = 0, m_mask = 0, m_op2 = 0, m_op3 = 2;
    int m_p2 = 0, m_p3 = 0, m_ce = 0, m_de = 0;

    always #2 clk = ~clk;   // 250 MHz

    pic_init_seq uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_byte(wr_byte),
        .cfg_state(cfg_state), .ready(ready),
        .icw1_q(icw1_q), .icw2_q(icw2_q), .icw3_q(icw3_q), .icw4_q(icw4_q),
        .imr_q(imr_q), .ocw2_q(ocw2_q), .ocw3_q(ocw3_q),
        .ocw2_stb(ocw2_stb), .ocw3_stb(ocw3_stb), .cmd_err(cmd_err), .data_err(data_err),
        .single_mode(single_mode), .need_icw4(need_icw4), .level_mode(level_mode),
        .auto_eoi(auto_eoi), .special_nested(special_nested)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // model update on each edge
    always @(posedge clk) begin
        m_p2 = 0; m_p3 = 0; m_ce = 0; m_de = 0;
        if (rst) begin
            m_st = 1; m_w1 = 0; m_w2 = 0; m_w3 = 0; m_w4 = 0;
            m_mask = 0; m_op2 = 0; m_op3 = 2;
        end else if (wr_en) begin
            if (!wr_sel) begin
                if (wr_byte[4]) begin
                    m_w1 = wr_byte; m_st = 2;
                end else if (m_st == 5) begin
                    if (wr_byte[3]) begin m_op3 = wr_byte; m_p3 = 1; end
                    else            begin m_op2 = wr_byte; m_p2 = 1; end
                end else m_ce = 1;
            end else begin
                case (m_st)
                    2: begin
                        m_w2 = wr_byte;
                        if ((m_w1 & 2) == 0)  m_st = 3;
                        else if (m_w1 & 1)    m_st = 4;
                        else                  m_st = 5;
                    end
                    3: begin m_w3 = wr_byte; m_st = (m_w1 & 1) ? 4 : 5; end
                    4: begin m_w4 = wr_byte; m_st = 5; end
                    5: m_mask = wr_byte;
                    default: m_de = 1;
                endcase
            end
        end
    end

    // compare every cycle, away from the edge
    always @(negedge clk) begin
        if (active) begin
            chk("R1/R2/R3/R4 state", cfg_state, m_st);
            chk("R11 ready", ready, (m_st == 5));
            chk("R2 word1", icw1_q, m_w1);
            chk("R3 word2", icw2_q, m_w2);
            chk("R4 word3", icw3_q, m_w3);
            chk("R4 word4", icw4_q, m_w4);
            chk("R5 mask", imr_q, m_mask);
            chk("R6 op2", ocw2_q, m_op2);
            chk("R7 op3", ocw3_q, m_op3);
            chk("R6 op2 strobe", ocw2_stb, m_p2);
            chk("R7 op3 strobe", ocw3_stb, m_p3);
            chk("R8 cmd error", cmd_err, m_ce);
            chk("R9 data error", data_err, m_de);
            chk("R10 single", single_mode, (m_w1 >> 1) & 1);
            chk("R10 need4", need_icw4, m_w1 & 1);
            chk("R10 level", level_mode, (m_w1 >> 3) & 1);
            chk("R10 aeoi", auto_eoi, (m_w4 >> 1) & 1);
            chk("R10 sfnm", special_nested, (m_w4 >> 4) & 1);
        end
    end

    task automatic wr(input bit sel, input logic [7:0] b);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_byte = b;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(4 * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        active = 1'b1;
        idle(2);                         // R1 reset values
        wr(1, 8'h55);                    // R9 data before setup
        wr(0, 8'h05);                    // R8 command without setup bit
        wr(0, 8'h11); wr(1, 8'h20); wr(1, 8'h04); wr(1, 8'h03);   // R3 R4 full path
        wr(1, 8'hA5);                    // R5 mask
        wr(0, 8'h20);                    // R6
        wr(0, 8'h0B); wr(0, 8'h08);      // R7
        idle(2);                         // R11 quiet
        wr(0, 8'h13); wr(1, 8'h70); wr(1, 8'h11);                 // single, mode word
        wr(0, 8'h1A); wr(1, 8'h08); wr(1, 8'h3C);                 // single, straight to ready
        wr(0, 8'h10); wr(1, 8'h40); wr(0, 8'h00); wr(1, 8'h02);   // cascade, no mode word; R8 mid-sequence
        wr(0, 8'h11); wr(1, 8'h50); wr(0, 8'h19); wr(1, 8'h60);   // R2 restart mid-sequence
        for (int i = 0; i < 400; i++) begin
            logic [7:0] b;
            b = 8'($urandom);
            if ((i % 7) == 0) b[4] = 1'b0;
            wr(1'($urandom), b);
            if ((i % 5) == 0) idle(1);
        end
        rst = 1'b1; idle(2); rst = 1'b0;                            // R1 again
        idle(2);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule